// File: doc/BRIEF.md
# Byte-Order Conversion Execution Unit

This unit is the byte-swap stage of a small 64-bit register-machine core. Each cycle it may accept one decoded instruction. The instruction is an 8-bit opcode and a 32-bit immediate, and it comes with the current value of the destination register. When the opcode names the byte-swap operation, the unit converts the register value to the requested byte order and width. One clock later it presents the new register value together with a write-enable.

The core that hosts the unit is taken to be little endian. A conversion to little endian therefore only truncates the value to the selected width. A conversion to big endian also reverses the order of the bytes inside that width. Each "from" form has the same encoding as the matching "to" form, so both behave the same. The unit reads no source register and no data operand, because the immediate carries only the width. An unrecognised opcode or an unsupported width raises an illegal-instruction flag, and no register write happens.

Top module: `bswap_unit`

## Requirements
- R1: The operation is recognised only when opcode bits [7:4] equal 4'hD and opcode bits [2:0] equal 3'h4 (the 32-bit ALU class). For any other opcode the result is flagged illegal, the write-enable is low and the result is zero.
- R2: With opcode bit 3 clear (little-endian order), the result equals the low N bits of the destination value, and bits N and above are zero.
- R3: With opcode bit 3 set (big-endian order), result byte k equals destination byte N/8-1-k for every k below N/8, and bits N and above are zero.
- R4: N is taken from the full 32-bit immediate, and only the values 16, 32 and 64 are legal. Any other immediate raises the illegal flag, holds the write-enable low and gives a zero result.
- R5: A result is registered. It appears, with a one-cycle output-valid pulse, in the cycle after each cycle in which the input-valid is high. Output-valid is low in the cycle after an idle input cycle.
- R6: While output-valid is high, exactly one of write-enable and illegal is high. While output-valid is low, both are low.
- R7: During and right after reset, output-valid, write-enable and illegal are low and the result is zero.
- R8: When inputs arrive in consecutive cycles, each one yields its own result in the cycle that follows it, with no stall and no bubble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A decoded instruction is present |
| in_opcode | input | 8 | Instruction opcode |
| in_imm | input | 32 | Immediate field, gives the conversion width |
| in_dst | input | 64 | Current destination register value |
| out_valid | output | 1 | Result present, one-cycle pulse |
| out_result | output | 64 | Converted register value |
| out_wen | output | 1 | Destination register write-enable |
| out_illegal | output | 1 | Illegal-instruction flag |

## Verification
Two events can fall in the same cycle: a result is presented at the output while the next instruction is sampled at the input. The bench provokes this by streaming instructions back to back, so that the output register is overwritten every cycle. Short idle gaps are inserted so that the bubble case is covered as well. Each output is compared with the value the bench computes from the instruction it applied one cycle earlier. This comparison catches any leak of the new input into the result being shown and any result that is held or dropped.

// File: rtl/bswap_unit.sv
module bswap_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_opcode,
  input  logic [31:0] in_imm,
  input  logic [63:0] in_dst,
  output logic        out_valid,
  output logic [63:0] out_result,
  output logic        out_wen,
  output logic        out_illegal
);

  localparam logic [3:0] OP_SWAP   = 4'hD;
  localparam logic [2:0] CLS_ALU32 = 3'h4;

  wire is_swap = (in_opcode[7:4] == OP_SWAP) && (in_opcode[2:0] == CLS_ALU32);
  wire to_big  = in_opcode[3];

  logic [3:0]  nbytes;
  logic        width_ok;
  logic [63:0] conv;

  always_comb begin
    width_ok = 1'b1;
    case (in_imm)
      32'd16:  nbytes = 4'd2;
      32'd32:  nbytes = 4'd4;
      32'd64:  nbytes = 4'd8;
      default: begin nbytes = 4'd0; width_ok = 1'b0; end
    endcase
  end

  always_comb begin
    conv = '0;
    for (int b = 0; b < 8; b++) begin
      if (4'(b) < nbytes) begin
        if (to_big)
          conv[8*b +: 8] = in_dst[8*(int'(nbytes) - 1 - b) +: 8];
        else
          conv[8*b +: 8] = in_dst[8*b +: 8];
      end
    end
  end

  wire legal = is_swap && width_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_wen     <= 1'b0;
      out_illegal <= 1'b0;
      out_result  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_wen     <= legal;
        out_illegal <= !legal;
        out_result  <= legal ? conv : '0;
      end else begin
        out_wen     <= 1'b0;
        out_illegal <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bswap_unit_chk.sv
module bswap_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [7:0]  in_opcode,
  input logic [31:0] in_imm,
  input logic [63:0] in_dst,
  input logic        out_valid,
  input logic [63:0] out_result,
  input logic        out_wen,
  input logic        out_illegal
);

  wire op_hit = (in_opcode[7:4] == 4'hD) && (in_opcode[2:0] == 3'h4);

  assert_bad_opcode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_hit) |=> (out_illegal && !out_wen && out_result == '0));

  assert_le_keep32_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_hit && !in_opcode[3] && in_imm == 32'd32)
      |=> (out_result[31:0] == $past(in_dst[31:0]) && out_result[63:32] == '0));

  assert_be_swap16_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_hit && in_opcode[3] && in_imm == 32'd16)
      |=> (out_result[7:0] == $past(in_dst[15:8]) && out_result[15:8] == $past(in_dst[7:0])
           && out_result[63:16] == '0));

  assert_bad_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_imm != 32'd16 && in_imm != 32'd32 && in_imm != 32'd64)
      |=> (out_illegal && !out_wen));

  assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_bubble_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_one_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot({out_wen, out_illegal}));

  assert_quiet_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_wen && !out_illegal));

  always_comb begin
    if (!rst_n) assert_reset_clear_R7: assert (!out_valid && !out_wen && !out_illegal);
  end

endmodule

bind bswap_unit bswap_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opcode(in_opcode),
  .in_imm(in_imm), .in_dst(in_dst), .out_valid(out_valid),
  .out_result(out_result), .out_wen(out_wen), .out_illegal(out_illegal)
);

// File: tb/bswap_unit_tb_top.sv
module bswap_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_opcode = '0;
  logic [31:0] in_imm = '0;
  logic [63:0] in_dst = '0;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_wen;
  logic        out_illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bit          p_have = 1'b0;
  bit          p_valid;
  bit          p_ok;
  logic [63:0] p_res;

  always #10 clk = ~clk;

  bswap_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opcode(in_opcode),
    .in_imm(in_imm), .in_dst(in_dst), .out_valid(out_valid),
    .out_result(out_result), .out_wen(out_wen), .out_illegal(out_illegal)
  );

  function automatic int width_bytes(logic [31:0] imm);
    if (imm == 32'd16) return 2;
    if (imm == 32'd32) return 4;
    if (imm == 32'd64) return 8;
    return 0;
  endfunction

  function automatic logic [63:0] model(logic big, int nb, logic [63:0] d);
    logic [63:0] r = '0;
    if (!big) begin
      r = (nb == 8) ? d : (d & ((64'd1 << (8*nb)) - 64'd1));
    end else begin
      for (int k = 0; k < nb; k++)
        r |= ((d >> (8*k)) & 64'hFF) << (8*(nb-1-k));
    end
    return r;
  endfunction

  task automatic check(bit cond, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_pending();
    if (!p_have) return;
    if (!p_valid) begin
      check(!out_valid && !out_wen && !out_illegal, "R5", "idle bubble",
            {61'd0, out_valid, out_wen, out_illegal}, 64'd0);
    end else begin
      check(out_valid, "R8", "valid after input", {63'd0, out_valid}, 64'd1);
      check(out_wen == p_ok && out_illegal == !p_ok, p_ok ? "R6" : "R4",
            "wen/illegal", {62'd0, out_wen, out_illegal}, {62'd0, p_ok, !p_ok});
      check(out_result == p_res, p_ok ? "R2/R3" : "R1", "result", out_result, p_res);
    end
  endtask

  task automatic apply(bit v, logic [7:0] op, logic [31:0] imm, logic [63:0] d);
    int nb;
    bit ok;
    @(negedge clk);
    check_pending();
    in_valid = v; in_opcode = op; in_imm = imm; in_dst = d;
    nb = width_bytes(imm);
    ok = (op[7:4] == 4'hD) && (op[2:0] == 3'h4) && (nb != 0);
    p_have = 1'b1;
    p_valid = v;
    p_ok = ok;
    p_res = ok ? model(op[3], nb, d) : 64'd0;
  endtask

  initial begin
    logic [31:0] imms [10];
    logic [63:0] dsts [4];
    int n = 0;
    imms = '{32'd0, 32'd8, 32'd16, 32'd24, 32'd32, 32'd48, 32'd64, 32'd128,
             32'h0001_0010, 32'hFFFF_FFFF};
    dsts = '{64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210,
             64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001};
    repeat (3) @(negedge clk);
    check(!out_valid && !out_wen && !out_illegal && out_result == '0, "R7", "in reset",
          out_result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !out_wen && !out_illegal, "R7", "after reset",
          {61'd0, out_valid, out_wen, out_illegal}, 64'd0);
    // R2/R3 spot checks on the two legal opcodes
    apply(1'b1, 8'hDC, 32'd16, 64'h1122_3344_5566_7788);
    apply(1'b1, 8'hD4, 32'd16, 64'h1122_3344_5566_7788);
    apply(1'b1, 8'hDC, 32'd64, 64'h1122_3344_5566_7788);
    apply(1'b0, 8'h00, 32'd0, 64'd0);
    // sweep: all opcodes x immediates x data, back to back with periodic gaps (R8, R5)
    for (int op = 0; op < 256; op++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 4; j++) begin
          n++;
          if (n % 7 == 0) apply(1'b0, 8'hD4, 32'd16, 64'd0);
          apply(1'b1, 8'(op), imms[i], dsts[j]);
        end
    apply(1'b0, 8'h00, 32'd0, 64'd0);
    apply(1'b0, 8'h00, 32'd0, 64'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule